// File: doc/BRIEF.md
# Nine-Bit Addressed Serial Receiver

This block receives asynchronous serial frames that carry nine bits of payload: a start bit, eight data bits sent least significant bit first, a ninth bit, and a stop bit. It is meant for a shared line on which one master talks to several slaves. The ninth bit tells the two kinds of frame apart: a 1 marks an address frame and a 0 marks a data frame. The line is sampled on a tick that runs at sixteen times the bit rate. Each bit is taken at its middle.

A filter flag decides which completed frames reach software. With the filter off, every good frame is stored and raises the receive-done flag. With the filter on, only address frames are stored and flagged, and data frames pass by unseen. Software drives the filter with set and clear pulses. In the usual flow, a slave clears its filter when it recognises its address and sets it again once the message is over.

An optional comparator can do the address recognition in hardware. It holds an own address and a mask, so that one slave can answer a group of addresses and one address can select several slaves. When auto mode is on and an address frame matches, the comparator drops the filter by itself. The done flag stays set until a clear pulse removes it. The overrun and framing error flags share a separate clear pulse.

Top module: `mp_uart_rx9`

## Requirements
- R1: After reset, rxDone, ovrErr, frmErr, rxBit9 and filtOn are 0, rxByte is 0, and the line is taken as idle (high).
- R2: A frame is a low start bit, eight data bits least significant bit first, the ninth bit, and a high stop bit, each 16 ovsTick periods long. An accepted frame loads the data into rxByte and the ninth bit into rxBit9.
- R3: With filtOn at 0, every frame that has a high stop bit is accepted and sets rxDone, whether its ninth bit is 0 or 1.
- R4: With filtOn at 1, a frame whose ninth bit is 0 is dropped: rxDone, rxByte and rxBit9 do not change. A frame whose ninth bit is 1 is accepted.
- R5: An address frame (ninth bit 1, high stop bit) clears filtOn when autoEn is 1 and ((byte XOR ownAddr) AND addrMask) is 0. If autoEn is 0, or if the masked compare differs, filtOn keeps its value.
- R6: A pulse on filtSet sets filtOn and a pulse on filtClr clears it. When filtSet is high, filtOn is 1 in the next cycle, even if filtClr or an automatic match falls in the same cycle.
- R7: A start bit that is high again at its middle (eighth tick) is dropped. It sets no flag and does not disturb the next real frame.
- R8: A frame whose stop bit is sampled low sets frmErr. It does not set rxDone and leaves rxByte and rxBit9 unchanged.
- R9: doneClr clears rxDone. A frame accepted while rxDone is still set sets ovrErr and replaces rxByte. errClr clears ovrErr and frmErr.
- R10: If a frame is accepted in the same cycle that doneClr is high, rxDone is set and ovrErr is not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| serIn | input | 1 | Serial line, idle high |
| ovsTick | input | 1 | One-cycle pulse at 16x the bit rate |
| filtSet | input | 1 | Pulse that turns the address filter on |
| filtClr | input | 1 | Pulse that turns the address filter off |
| autoEn | input | 1 | Lets an address match clear the filter |
| ownAddr | input | DATA_W | Address of this receiver |
| addrMask | input | DATA_W | Bits of the address that take part in the compare |
| doneClr | input | 1 | Write-one-to-clear for rxDone |
| errClr | input | 1 | Write-one-to-clear for ovrErr and frmErr |
| rxByte | output | DATA_W | Last accepted data byte |
| rxBit9 | output | 1 | Ninth bit of the last accepted frame |
| rxDone | output | 1 | Receive-done interrupt flag |
| ovrErr | output | 1 | Frame accepted while rxDone was set |
| frmErr | output | 1 | Stop bit sampled low |
| filtOn | output | 1 | Address filter state |

## Verification
Two functions can land on the same clock edge: software clearing the done flag, and a new frame completing and setting that flag. The filter has the same kind of conflict, where a software set can meet an automatic clear from a matching address. The exact completion edge depends on where the start edge falls relative to the oversampling tick. The bench therefore holds the clear (or set) input high through the whole frame, so that it is certain to overlap whichever cycle the frame completes in. The design passes if rxDone shows as a single-cycle pulse carrying the expected byte while ovrErr stays 0, and if filtOn never drops during the matching frame that was sent with filtSet held high.

// File: rtl/mp_rx9_pkg.sv
package mp_rx9_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_BITS,
    ST_STOP
  } rxState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic shiftEn;   // sample the line into the shift register
    logic frameEnd;  // sample the stop bit and settle the frame
  } rxStrobe_t;

endpackage

// File: rtl/mp_rx9_ctrl.sv
module mp_rx9_ctrl
  import mp_rx9_pkg::*;
#(
  parameter int OVS        = 16,
  parameter int FRAME_BITS = 9
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      ovsTick,
  input  logic      lineS,
  output rxStrobe_t strobe
);

  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

  rxState_t          state;
  logic [CNT_W-1:0]  tickCnt;
  logic [BIT_W-1:0]  bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (ovsTick) begin
      unique case (state)
        ST_IDLE: begin
          tickCnt <= '0;
          if (!lineS) state <= ST_START;
        end
        ST_START: begin
          if (tickCnt == MID) begin
            tickCnt <= '0;
            bitCnt  <= '0;
            // a start bit that is gone at mid-bit was noise
            state   <= lineS ? ST_IDLE : ST_BITS;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_BITS: begin
          if (tickCnt == LAST) begin
            tickCnt <= '0;
            if (bitCnt == LAST_BIT) state <= ST_STOP;
            else bitCnt <= bitCnt + 1'b1;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (tickCnt == LAST) begin
            tickCnt <= '0;
            state   <= ST_IDLE;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.shiftEn  = ovsTick && (state == ST_BITS) && (tickCnt == LAST);
    strobe.frameEnd = ovsTick && (state == ST_STOP) && (tickCnt == LAST);
  end

endmodule

// File: rtl/mp_rx9_match.sv
module mp_rx9_match #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] rxData,
  input  logic [DATA_W-1:0] ownAddr,
  input  logic [DATA_W-1:0] addrMask,
  output logic              hit
);

  logic [DATA_W-1:0] diffBit;

  for (genvar i = 0; i < DATA_W; i++) begin : g_cmp
    assign diffBit[i] = (rxData[i] ^ ownAddr[i]) & addrMask[i];
  end

  assign hit = (diffBit == '0);

endmodule

// File: rtl/mp_rx9_dp.sv
module mp_rx9_dp
  import mp_rx9_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  rxStrobe_t         strobe,
  input  logic              filtSet,
  input  logic              filtClr,
  input  logic              autoEn,
  input  logic [DATA_W-1:0] ownAddr,
  input  logic [DATA_W-1:0] addrMask,
  input  logic              doneClr,
  input  logic              errClr,
  output logic              lineS,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxBit9,
  output logic              rxDone,
  output logic              ovrErr,
  output logic              frmErr,
  output logic              filtOn
);

  localparam int FRAME_BITS = DATA_W + 1;

  logic [1:0]            syncQ;
  logic [FRAME_BITS-1:0] shiftQ;
  logic                  stopOk;
  logic                  ninth;
  logic                  accept;
  logic                  cmpHit;
  logic                  autoHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], serIn};
  end
  assign lineS = syncQ[1];

  // least significant bit arrives first and ends up at bit 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shiftQ <= '0;
    else if (strobe.shiftEn) shiftQ <= {lineS, shiftQ[FRAME_BITS-1:1]};
  end

  assign ninth  = shiftQ[DATA_W];
  assign stopOk = strobe.frameEnd && lineS;
  assign accept = stopOk && (!filtOn || ninth);

  mp_rx9_match #(.DATA_W(DATA_W)) u_match (
    .rxData   (shiftQ[DATA_W-1:0]),
    .ownAddr  (ownAddr),
    .addrMask (addrMask),
    .hit      (cmpHit)
  );

  assign autoHit = stopOk && ninth && autoEn && cmpHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      rxBit9 <= 1'b0;
    end else if (accept) begin
      rxByte <= shiftQ[DATA_W-1:0];
      rxBit9 <= ninth;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxDone <= 1'b0;
      ovrErr <= 1'b0;
      frmErr <= 1'b0;
      filtOn <= 1'b0;
    end else begin
      // completion takes priority over a clear in the same cycle
      if (accept)       rxDone <= 1'b1;
      else if (doneClr) rxDone <= 1'b0;

      if (accept && rxDone && !doneClr) ovrErr <= 1'b1;
      else if (errClr)                  ovrErr <= 1'b0;

      if (strobe.frameEnd && !lineS) frmErr <= 1'b0 | 1'b1;
      else if (errClr)               frmErr <= 1'b0;

      if (filtSet)                 filtOn <= 1'b1;
      else if (filtClr || autoHit) filtOn <= 1'b0;
    end
  end

endmodule

// File: rtl/mp_uart_rx9.sv
module mp_uart_rx9
  import mp_rx9_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  logic              ovsTick,
  input  logic              filtSet,
  input  logic              filtClr,
  input  logic              autoEn,
  input  logic [DATA_W-1:0] ownAddr,
  input  logic [DATA_W-1:0] addrMask,
  input  logic              doneClr,
  input  logic              errClr,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxBit9,
  output logic              rxDone,
  output logic              ovrErr,
  output logic              frmErr,
  output logic              filtOn
);

  localparam int FRAME_BITS = DATA_W + 1;

  rxStrobe_t strobe;
  logic      lineS;

  mp_rx9_ctrl #(.OVS(OVS), .FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ovsTick (ovsTick),
    .lineS   (lineS),
    .strobe  (strobe)
  );

  mp_rx9_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .serIn    (serIn),
    .strobe   (strobe),
    .filtSet  (filtSet),
    .filtClr  (filtClr),
    .autoEn   (autoEn),
    .ownAddr  (ownAddr),
    .addrMask (addrMask),
    .doneClr  (doneClr),
    .errClr   (errClr),
    .lineS    (lineS),
    .rxByte   (rxByte),
    .rxBit9   (rxBit9),
    .rxDone   (rxDone),
    .ovrErr   (ovrErr),
    .frmErr   (frmErr),
    .filtOn   (filtOn)
  );

endmodule

// File: rtl/mp_rx9_chk.sv
module mp_rx9_chk (
  input logic clk,
  input logic rstN,
  input logic filtSet,
  input logic filtClr,
  input logic autoEn,
  input logic doneClr,
  input logic rxDone,
  input logic rxBit9,
  input logic ovrErr,
  input logic frmErr,
  input logic filtOn
);

  // R4: with the filter on, only an address frame can raise the flag
  p_filter_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxDone) && $past(filtOn)) |-> rxBit9);

  // R5: the filter only drops through software or an automatic match
  p_filter_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(filtOn) |-> ($past(filtClr) || $past(autoEn)));

  // R6: a software set always wins
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(filtSet) |-> filtOn);

  // R8: a framing error never comes with a new done flag
  p_frm_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frmErr) |-> !$rose(rxDone));

  // R9: overrun only while the done flag is already up
  p_ovr_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrErr) |-> $past(rxDone));

  // R9: the done flag only drops on a clear request
  p_done_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxDone) |-> $past(doneClr));

endmodule

bind mp_uart_rx9 mp_rx9_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .filtSet (filtSet),
  .filtClr (filtClr),
  .autoEn  (autoEn),
  .doneClr (doneClr),
  .rxDone  (rxDone),
  .rxBit9  (rxBit9),
  .ovrErr  (ovrErr),
  .frmErr  (frmErr),
  .filtOn  (filtOn)
);

// File: tb/mp_uart_rx9_bench.sv
module mp_uart_rx9_bench;

  localparam int BIT_CLKS = 64;  // 16 ticks of 4 clocks

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serIn = 1'b1;
  logic       ovsTick = 1'b0;
  logic       filtSet = 1'b0;
  logic       filtClr = 1'b0;
  logic       autoEn = 1'b0;
  logic [7:0] ownAddr = 8'h00;
  logic [7:0] addrMask = 8'h00;
  logic       doneClr = 1'b0;
  logic       errClr = 1'b0;
  logic [7:0] rxByte;
  logic       rxBit9;
  logic       rxDone;
  logic       ovrErr;
  logic       frmErr;
  logic       filtOn;

  int errors = 0;
  int checks = 0;

  typedef struct { logic [7:0] b; logic n; } exp_t;
  exp_t expQ[$];

  logic prevDone = 1'b0;
  logic cntEn = 1'b0;
  int   doneHi = 0;
  int   filtLo = 0;
  int   tickDiv = 0;

  mp_uart_rx9 u_mp_uart_rx9 (
    .clk(clk), .rstN(rstN), .serIn(serIn), .ovsTick(ovsTick),
    .filtSet(filtSet), .filtClr(filtClr), .autoEn(autoEn),
    .ownAddr(ownAddr), .addrMask(addrMask), .doneClr(doneClr),
    .errClr(errClr), .rxByte(rxByte), .rxBit9(rxBit9), .rxDone(rxDone),
    .ovrErr(ovrErr), .frmErr(frmErr), .filtOn(filtOn)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tickDiv <= (tickDiv == 3) ? 0 : tickDiv + 1;
    ovsTick <= (tickDiv == 3);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compare each new done flag with the next queued item (R2)
  always @(negedge clk) begin
    if (rstN && rxDone && !prevDone) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R2", "unexpected frame", rxByte, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk(rxByte == e.b, "R2", "byte", rxByte, e.b);
        chk(rxBit9 == e.n, "R2", "ninth bit", rxBit9, e.n);
      end
    end
    prevDone = rxDone;
    if (cntEn) begin
      if (rxDone) doneHi++;
      if (!filtOn) filtLo++;
    end
  end

  task automatic holdBit(input logic v);
    serIn = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] b, input logic n,
                           input logic stopv, input bit expAcc);
    if (expAcc) expQ.push_back('{b: b, n: n});
    holdBit(1'b0);
    for (int i = 0; i < 8; i++) holdBit(b[i]);
    holdBit(n);
    holdBit(stopv);
    holdBit(1'b1);
    holdBit(1'b1);
  endtask

  task automatic pulseDoneClr();
    doneClr = 1'b1; @(negedge clk); doneClr = 1'b0; @(negedge clk);
  endtask

  task automatic pulseErrClr();
    errClr = 1'b1; @(negedge clk); errClr = 1'b0; @(negedge clk);
  endtask

  task automatic pulseFilt(input logic s, input logic c);
    filtSet = s; filtClr = c; @(negedge clk);
    filtSet = 1'b0; filtClr = 1'b0; @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(rxDone == 0 && ovrErr == 0 && frmErr == 0, "R1", "flags", {rxDone, ovrErr, frmErr}, 0);
    chk(rxByte == 0 && rxBit9 == 0 && filtOn == 0, "R1", "data/filter", {rxBit9, filtOn, rxByte}, 0);
    rstN = 1'b1;
    repeat (8) @(negedge clk);

    // R3: filter off accepts data and address frames
    sendFrame(8'hA5, 1'b0, 1'b1, 1);
    chk(rxDone == 1, "R3", "done after data frame", rxDone, 1);
    pulseDoneClr();
    chk(rxDone == 0, "R9", "done cleared", rxDone, 0);
    sendFrame(8'h3C, 1'b1, 1'b1, 1);
    chk(rxDone == 1, "R3", "done after address frame", rxDone, 1);
    pulseDoneClr();

    // R4: filter on drops data frames
    pulseFilt(1'b1, 1'b0);
    chk(filtOn == 1, "R6", "filter set", filtOn, 1);
    sendFrame(8'h55, 1'b0, 1'b1, 0);
    chk(rxDone == 0, "R4", "data frame flagged", rxDone, 0);
    chk(rxByte == 8'h3C && rxBit9 == 1, "R4", "byte held", {rxBit9, rxByte}, 9'h13C);

    // R5: no automatic drop while autoEn is off
    ownAddr = 8'h40; addrMask = 8'hFE;
    sendFrame(8'h41, 1'b1, 1'b1, 1);
    chk(rxDone == 1, "R4", "address frame accepted", rxDone, 1);
    chk(filtOn == 1, "R5", "filter kept without autoEn", filtOn, 1);
    pulseDoneClr();

    // R5: masked match clears the filter
    autoEn = 1'b1;
    sendFrame(8'h41, 1'b1, 1'b1, 1);
    chk(filtOn == 0, "R5", "filter dropped on match", filtOn, 0);
    pulseDoneClr();
    sendFrame(8'h77, 1'b0, 1'b1, 1);
    chk(rxDone == 1, "R4", "data after match", rxDone, 1);
    pulseDoneClr();

    // R5: mismatch under mask keeps the filter
    pulseFilt(1'b1, 1'b0);
    sendFrame(8'h43, 1'b1, 1'b1, 1);
    chk(filtOn == 1, "R5", "filter kept on mismatch", filtOn, 1);
    pulseDoneClr();

    // R6: clear, then set and clear together
    pulseFilt(1'b0, 1'b1);
    chk(filtOn == 0, "R6", "filter cleared", filtOn, 0);
    pulseFilt(1'b1, 1'b1);
    chk(filtOn == 1, "R6", "set wins over clear", filtOn, 1);
    pulseFilt(1'b0, 1'b1);

    // R7: short glitch then a real frame
    serIn = 1'b0;
    repeat (16) @(negedge clk);
    serIn = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    chk(rxDone == 0 && frmErr == 0, "R7", "glitch flagged", {rxDone, frmErr}, 0);
    sendFrame(8'h96, 1'b0, 1'b1, 1);
    chk(rxDone == 1, "R7", "frame after glitch", rxDone, 1);
    pulseDoneClr();

    // R8: low stop bit
    sendFrame(8'h0F, 1'b1, 1'b0, 0);
    chk(frmErr == 1, "R8", "framing error", frmErr, 1);
    chk(rxDone == 0, "R8", "no done", rxDone, 0);
    chk(rxByte == 8'h96, "R8", "byte held", rxByte, 8'h96);
    pulseErrClr();
    chk(frmErr == 0, "R9", "frmErr cleared", frmErr, 0);

    // R9: overrun
    sendFrame(8'h11, 1'b0, 1'b1, 1);
    sendFrame(8'h22, 1'b1, 1'b1, 0);
    chk(ovrErr == 1 && rxDone == 1, "R9", "overrun", {ovrErr, rxDone}, 2'b11);
    chk(rxByte == 8'h22, "R9", "byte replaced", rxByte, 8'h22);
    pulseErrClr();
    chk(ovrErr == 0, "R9", "ovrErr cleared", ovrErr, 0);

    // R10: clear held through a completing frame
    doneHi = 0;
    doneClr = 1'b1;
    repeat (2) @(negedge clk);
    cntEn = 1'b1;
    sendFrame(8'hC3, 1'b0, 1'b1, 1);
    cntEn = 1'b0;
    doneClr = 1'b0;
    chk(doneHi == 1, "R10", "done pulse cycles", doneHi, 1);
    chk(ovrErr == 0, "R10", "no overrun", ovrErr, 0);

    // R6: set held through a matching address frame
    filtLo = 0;
    filtSet = 1'b1;
    @(negedge clk);
    cntEn = 1'b1;
    sendFrame(8'h40, 1'b1, 1'b1, 1);
    cntEn = 1'b0;
    filtSet = 1'b0;
    chk(filtLo == 0, "R6", "filter low cycles", filtLo, 0);
    pulseDoneClr();

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R2", "frames left in queue", expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule